// File: doc/BRIEF.md
# Four-phase fetch-execute sequencer

This block runs the instruction cycle of a small processor core. It turns the oscillator clock into four non-overlapping one-hot phase strobes (phase 1 to phase 4). One pass through all four is one instruction cycle. It holds a 13-bit program counter that addresses program memory. It also holds an instruction register that takes the fetched word at each cycle boundary. The next word is fetched while the current word executes. The decoder, the ALU and the return stack sit outside this block. They see the latched word, a data-memory read strobe in phase 2 and a write strobe in phase 4.

A jump request or an interrupt request changes the program counter. The target address arrives on a port. An interrupt always goes to a fixed vector address. When the counter is redirected, the word fetched alongside is thrown away and an all-zero word takes its place. That bubble cycle raises no read or write strobe, so any redirection costs two cycles. The program counter counts over its full 13 bits. The address sent to memory is masked to the implemented memory size, so aliased addresses fetch the same word. A registered divided-clock output runs at a quarter of the input clock and marks the instruction-cycle rate.

Top module: `quad_fetch_seq`

## Requirements
- R1: `phase_o` is one-hot: bit 0 is phase 1, bit 1 is phase 2, bit 2 is phase 3 and bit 3 is phase 4. It steps 1→2→3→4→1 on every input clock edge and shows phase 1 during reset.
- R2: `clkout_o` is high during phases 1 and 2 and low during phases 3 and 4. It therefore runs at one quarter of the input clock.
- R3: During reset and through the whole first instruction cycle after reset, `imem_addr_o` is 0 and `instr_o` is all zeros. In that first cycle both enables stay low, because it is a bubble.
- R4: With no requests, `imem_addr_o` holds steady within a cycle and moves up by one as the next phase 1 begins.
- R5: The word on `imem_data_i` at the end of phase 4 is shown on `instr_o` for the whole following instruction cycle.
- R6: In a cycle that executes a fetched word, `rd_en_o` is high only in phase 2 and `wr_en_o` is high only in phase 4.
- R7: `br_req_i` high at the end of phase 4 of a non-bubble cycle loads `br_tgt_i` into the program counter. The next cycle is a bubble: `instr_o` is all zeros and neither enable rises.
- R8: `irq_req_i` high at the end of phase 4 loads the vector address 4 and makes the next cycle a bubble. This happens in any cycle, bubbles included. It wins over a jump requested in the same cycle.
- R9: A jump request during a bubble cycle is ignored, and fetching carries on sequentially.
- R10: Requests held only in phases 1 to 3 and dropped before the end of phase 4 have no effect.
- R11: `imem_addr_o` equals the program counter with every bit at or above log2(MEM_WORDS) forced to zero. The counter itself counts and wraps over all 13 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously |
| imem_data_i | input | 14 | Word read from program memory at `imem_addr_o` |
| br_req_i | input | 1 | Jump request from the executing word |
| br_tgt_i | input | 13 | Jump target address |
| irq_req_i | input | 1 | Interrupt acceptance request |
| imem_addr_o | output | 13 | Masked program memory address |
| instr_o | output | 14 | Instruction register |
| phase_o | output | 4 | One-hot phase strobes |
| rd_en_o | output | 1 | Operand read enable (phase 2) |
| wr_en_o | output | 1 | Result write enable (phase 4) |
| clkout_o | output | 1 | Quarter-rate clock output |

## Verification
Two redirections can land on the same cycle end. An interrupt can arrive together with a jump, or either request can arrive during the bubble left by an earlier one. The bench provokes both cases directly. It then runs a long pseudo-random stream of requests on top of them. A bench model tracks the expected counter, the instruction register and a bubble flag, and it applies the priority rule (interrupt over jump, jump ignored in a bubble). The address, the instruction and the enables are judged in every phase of the cycle that follows.

// File: rtl/quad_seq_pkg.sv
package quad_seq_pkg;
  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;
  localparam int unsigned NUM_PHASES = 4;
endpackage

// File: rtl/qs_phase_gen.sv
module qs_phase_gen
  import quad_seq_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [NUM_PHASES-1:0] strobe_o,
  output logic                  clkout_o
);
  phase_e ph_q, ph_d;
  logic   div_q, div_d;

  always_comb begin
    ph_d  = phase_e'(ph_q + 2'd1);
    div_d = (ph_d == PH_Q1) || (ph_d == PH_Q2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_Q1;
      div_q <= 1'b1;
    end else begin
      ph_q  <= ph_d;
      div_q <= div_d;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PHASES; i++) begin
      strobe_o[i] = (ph_q == phase_e'(i));
    end
  end

  assign clkout_o = div_q;
endmodule

// File: rtl/qs_pc_unit.sv
module qs_pc_unit #(
  parameter int unsigned PC_W      = 13,
  parameter int unsigned MEM_WORDS = 1024,
  parameter int unsigned RST_VEC   = 0,
  parameter int unsigned IRQ_VEC   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            irq_i,
  input  logic            br_i,
  input  logic [PC_W-1:0] tgt_i,
  output logic [PC_W-1:0] addr_o
);
  localparam int unsigned     AW       = $clog2(MEM_WORDS);
  localparam logic [PC_W-1:0] ADDR_MSK = PC_W'((64'd1 << AW) - 64'd1);
  localparam logic [PC_W-1:0] RST_PC   = PC_W'(RST_VEC);
  localparam logic [PC_W-1:0] IRQ_PC   = PC_W'(IRQ_VEC);

  logic [PC_W-1:0] pc_q, pc_d;

  always_comb begin
    pc_d = pc_q;
    if (adv_i) begin
      if (irq_i)     pc_d = IRQ_PC;
      else if (br_i) pc_d = tgt_i;
      else           pc_d = pc_q + PC_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= RST_PC;
    else if (adv_i) pc_q <= pc_d;
  end

  assign addr_o = pc_q & ADDR_MSK;
endmodule

// File: rtl/qs_ir_stage.sv
module qs_ir_stage #(
  parameter int unsigned IW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          flush_i,
  input  logic [IW-1:0] word_i,
  output logic [IW-1:0] ir_o,
  output logic          valid_o
);
  logic [IW-1:0] ir_q, ir_d;
  logic          val_q, val_d;

  always_comb begin
    ir_d  = flush_i ? '0 : word_i;
    val_d = !flush_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q  <= '0;
      val_q <= 1'b0;
    end else if (adv_i) begin
      ir_q  <= ir_d;
      val_q <= val_d;
    end
  end

  assign ir_o    = ir_q;
  assign valid_o = val_q;
endmodule

// File: rtl/quad_fetch_seq.sv
module quad_fetch_seq #(
  parameter int unsigned PC_W      = 13,
  parameter int unsigned IW        = 14,
  parameter int unsigned MEM_WORDS = 1024,
  parameter int unsigned RST_VEC   = 0,
  parameter int unsigned IRQ_VEC   = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IW-1:0]   imem_data_i,
  input  logic            br_req_i,
  input  logic [PC_W-1:0] br_tgt_i,
  input  logic            irq_req_i,
  output logic [PC_W-1:0] imem_addr_o,
  output logic [IW-1:0]   instr_o,
  output logic [3:0]      phase_o,
  output logic            rd_en_o,
  output logic            wr_en_o,
  output logic            clkout_o
);
  logic [3:0] strobe;
  logic       cyc_end, exec_valid, take_br, flush;

  qs_phase_gen u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_o (strobe),
    .clkout_o (clkout_o)
  );

  assign cyc_end = strobe[3];
  assign take_br = br_req_i & exec_valid;
  assign flush   = irq_req_i | take_br;

  qs_pc_unit #(
    .PC_W(PC_W), .MEM_WORDS(MEM_WORDS), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)
  ) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (cyc_end),
    .irq_i  (irq_req_i),
    .br_i   (take_br),
    .tgt_i  (br_tgt_i),
    .addr_o (imem_addr_o)
  );

  qs_ir_stage #(.IW(IW)) u_ir (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (cyc_end),
    .flush_i (flush),
    .word_i  (imem_data_i),
    .ir_o    (instr_o),
    .valid_o (exec_valid)
  );

  assign phase_o = strobe;
  assign rd_en_o = exec_valid & strobe[1];
  assign wr_en_o = exec_valid & strobe[3];
endmodule

// File: rtl/quad_fetch_seq_chk.sv
module quad_fetch_seq_chk #(
  parameter int unsigned PC_W      = 13,
  parameter int unsigned IW        = 14,
  parameter int unsigned MEM_WORDS = 1024,
  parameter int unsigned IRQ_VEC   = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [3:0]      phase_o,
  input logic            clkout_o,
  input logic            rd_en_o,
  input logic            wr_en_o,
  input logic            irq_req_i,
  input logic [PC_W-1:0] imem_addr_o,
  input logic [IW-1:0]   instr_o
);
  localparam int unsigned     AW       = $clog2(MEM_WORDS);
  localparam logic [PC_W-1:0] IRQ_ADDR = PC_W'(IRQ_VEC) & PC_W'((64'd1 << AW) - 64'd1);

  AST_PHASE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(phase_o) == 1); // R1
  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o[3] |=> phase_o[0]); // R1
  AST_CLKOUT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clkout_o) |-> phase_o[0]); // R2
  AST_CLKOUT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clkout_o) |-> phase_o[2]); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o[0] |-> $stable(imem_addr_o)); // R4
  AST_INSTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o[0] |-> $stable(instr_o)); // R5
  AST_RD_IN_Q2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> phase_o[1]); // R6
  AST_WR_IN_Q4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> phase_o[3]); // R6
  AST_IRQ_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o[3] && irq_req_i) |=> (imem_addr_o == IRQ_ADDR && instr_o == '0)); // R8
endmodule

bind quad_fetch_seq quad_fetch_seq_chk #(
  .PC_W(PC_W), .IW(IW), .MEM_WORDS(MEM_WORDS), .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_o     (phase_o),
  .clkout_o    (clkout_o),
  .rd_en_o     (rd_en_o),
  .wr_en_o     (wr_en_o),
  .irq_req_i   (irq_req_i),
  .imem_addr_o (imem_addr_o),
  .instr_o     (instr_o)
);

// File: tb/sim_quad_fetch_seq.sv
module sim_quad_fetch_seq;
  localparam logic [12:0] MSK = 13'h03FF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] imem_data;
  logic        br_req, irq_req;
  logic [12:0] br_tgt;
  logic [12:0] imem_addr;
  logic [13:0] instr;
  logic [3:0]  phase;
  logic        rd_en, wr_en, clkout;

  always #10 clk = ~clk;

  quad_fetch_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .imem_data_i(imem_data), .br_req_i(br_req),
    .br_tgt_i(br_tgt), .irq_req_i(irq_req), .imem_addr_o(imem_addr),
    .instr_o(instr), .phase_o(phase), .rd_en_o(rd_en), .wr_en_o(wr_en),
    .clkout_o(clkout)
  );

  // program memory model: every word is distinct and nonzero
  assign imem_data = {1'b1, imem_addr};

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [12:0] e_pc;
  logic [13:0] e_ir;
  logic        e_val;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one instruction cycle: eb/ei held in phases 1..3, br/irq at phase 4
  task automatic icycle(input string scen, input logic br, input logic [12:0] tgt,
                        input logic irq, input logic eb, input logic ei);
    logic [13:0] word;
    for (int k = 0; k < 4; k++) begin
      chk({scen, " R1 phase"}, 32'(phase), 32'(1 << k));
      chk({scen, " R2 clkout"}, 32'(clkout), 32'(k < 2));
      chk({scen, " R4 R11 address"}, 32'(imem_addr), 32'(e_pc & MSK));
      chk({scen, " R5 instr"}, 32'(instr), 32'(e_ir));
      chk({scen, " R6 rd_en"}, 32'(rd_en), 32'(e_val && k == 1));
      chk({scen, " R6 wr_en"}, 32'(wr_en), 32'(e_val && k == 3));
      br_tgt  = tgt;
      br_req  = (k == 3) ? br  : eb;
      irq_req = (k == 3) ? irq : ei;
      @(negedge clk);
    end
    word = {1'b1, e_pc & MSK};
    if (irq) begin
      e_pc = 13'h0004; e_ir = '0; e_val = 1'b0;
    end else if (br && e_val) begin
      e_pc = tgt; e_ir = '0; e_val = 1'b0;
    end else begin
      e_pc = e_pc + 13'd1; e_ir = word; e_val = 1'b1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] lf;
    rst_n = 1'b0; br_req = 1'b0; irq_req = 1'b0; br_tgt = '0;
    repeat (3) @(negedge clk);
    chk("R3 reset phase", 32'(phase), 32'h1);
    chk("R3 reset addr", 32'(imem_addr), 32'h0);
    chk("R3 reset instr", 32'(instr), 32'h0);
    chk("R3 reset rd_en", 32'(rd_en), 32'h0);
    chk("R3 reset wr_en", 32'(wr_en), 32'h0);
    chk("R3 reset clkout", 32'(clkout), 32'h1);
    e_pc = '0; e_ir = '0; e_val = 1'b0;
    rst_n = 1'b1;
    icycle("R3 first bubble", 1'b1, 13'h0777, 1'b0, 1'b0, 1'b0);
    repeat (5) icycle("R4 R5 sequential", 1'b0, '0, 1'b0, 1'b0, 1'b0);
    icycle("R7 branch", 1'b1, 13'h1420, 1'b0, 1'b0, 1'b0);
    icycle("R9 branch in bubble", 1'b1, 13'h0155, 1'b0, 1'b0, 1'b0);
    repeat (3) icycle("R11 aliased run", 1'b0, '0, 1'b0, 1'b0, 1'b0);
    icycle("R10 early requests", 1'b0, 13'h00AA, 1'b0, 1'b1, 1'b1);
    icycle("R10 after early", 1'b0, '0, 1'b0, 1'b0, 1'b0);
    icycle("R8 interrupt", 1'b0, '0, 1'b1, 1'b0, 1'b0);
    repeat (2) icycle("R8 after vector", 1'b0, '0, 1'b0, 1'b0, 1'b0);
    icycle("R8 irq beats branch", 1'b1, 13'h0300, 1'b1, 1'b0, 1'b0);
    icycle("R8 irq in bubble", 1'b0, '0, 1'b1, 1'b0, 1'b0);
    repeat (2) icycle("R8 after bubble irq", 1'b0, '0, 1'b0, 1'b0, 1'b0);
    icycle("R11 branch near top", 1'b1, 13'h1FFE, 1'b0, 1'b0, 1'b0);
    repeat (4) icycle("R11 counter wrap", 1'b0, '0, 1'b0, 1'b0, 1'b0);
    lf = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      icycle("R7 R8 R9 mixed", lf[0] & lf[1], lf[14:2], lf[3] & lf[4] & lf[5],
             lf[6] & lf[7], lf[8] & lf[9]);
    end
    finish_run();
  end
endmodule